// File: doc/BRIEF.md
# Packed Unsigned Halving Add/Subtract Unit

This block is a small SIMD arithmetic stage. It takes two 32-bit operands, A and B, and a 3-bit operation select. It treats the operands either as two 16-bit halfword lanes or as four 8-bit byte lanes. In each lane it forms the unsigned sum or difference one bit wider than the lane, then drops the least significant bit. The carry or borrow therefore lands in the top bit of the lane result. Two halfword operations exchange the halves of B before combining, and they add in one lane while subtracting in the other.

Each operation is presented with an input valid strobe. The result, a matching valid and a flag for unassigned select codes appear on registered outputs one clock later. An unassigned select code raises the flag and leaves the previous result in place. The block is meant to sit behind an instruction decoder that has already read the operands.

Top module: `phu_unit`

## Requirements
- R1: Select 0 (halfword add): result[15:0] = (A[15:0]+B[15:0]) >> 1 and result[31:16] = (A[31:16]+B[31:16]) >> 1, each sum 17 bits wide.
- R2: Select 1 (exchange, subtract low): result[15:0] = (A[15:0]-B[31:16]) >> 1 and result[31:16] = (A[31:16]+B[15:0]) >> 1.
- R3: Select 2 (exchange, add low): result[15:0] = (A[15:0]+B[31:16]) >> 1 and result[31:16] = (A[31:16]-B[15:0]) >> 1.
- R4: Select 3 (halfword subtract): result[15:0] = (A[15:0]-B[15:0]) >> 1 and result[31:16] = (A[31:16]-B[31:16]) >> 1.
- R5: Select 4 (byte add): for each byte k from 0 to 3, result[8k+7:8k] = (A byte k + B byte k) >> 1, each sum 9 bits wide.
- R6: Select 7 (byte subtract): for each byte k, result[8k+7:8k] = (A byte k - B byte k) >> 1.
- R7: A difference wraps modulo 2^(W+1) for lane width W. When A is less than B in a lane, bit W-1 of that lane's result is 1.
- R8: No carry or borrow passes from one lane into another. Lane 0 occupies the least significant bits.
- R9: When a valid input carries select 5 or 6, the next cycle shows out_undef=1 and out_result unchanged.
- R10: out_valid equals in_valid of the previous cycle. out_undef is 0 after any cycle whose input is a valid defined operation or is not valid. out_result changes only after a valid defined operation.
- R11: A synchronous active-high rst clears out_valid, out_undef and out_result to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and select are valid this cycle |
| op_sel | input | 3 | Operation select |
| opnd_a | input | 32 | First operand A |
| opnd_b | input | 32 | Second operand B |
| out_valid | output | 1 | Registered result valid |
| out_result | output | 32 | Registered packed lane results |
| out_undef | output | 1 | Previous valid input used an unassigned select |

## Verification
The hardest case to reach from the ports is a lane whose top bit depends only on the borrow or carry, while the neighbouring lane must show that nothing leaked across. Random operands rarely produce this. The stimulus therefore applies directed operand pairs to every select code: all ones, all zeros, A below B in every lane at once, and lane patterns such as 0x00FF00FF plus 0x00010001 that overflow exactly at the lane boundary. Undefined selects are placed straight after a defined result, and idle cycles are placed between them, so that the held result can be seen.

// File: rtl/phu_pkg.sv
package phu_pkg;

    typedef enum logic [2:0] {
        OP_ADD_H   = 3'd0,
        OP_XSUBADD = 3'd1,
        OP_XADDSUB = 3'd2,
        OP_SUB_H   = 3'd3,
        OP_ADD_B   = 3'd4,
        OP_RSV5    = 3'd5,
        OP_RSV6    = 3'd6,
        OP_SUB_B   = 3'd7
    } phu_op_e;

    // Decoded lane controls carried through the datapath
    typedef struct packed {
        logic swap_b;     // exchange halves of operand B
        logic sub_lo;     // low halfword lane subtracts
        logic sub_hi;     // high halfword lane subtracts
        logic byte_mode;  // select byte lanes
        logic sub_byte;   // byte lanes subtract
        logic undef;      // unassigned select code
    } phu_ctrl_t;

    function automatic phu_ctrl_t phu_decode(input phu_op_e op);
        phu_ctrl_t c;
        c = '0;
        case (op)
            OP_ADD_H:   c = '0;
            OP_XSUBADD: begin c.swap_b = 1'b1; c.sub_lo = 1'b1; end
            OP_XADDSUB: begin c.swap_b = 1'b1; c.sub_hi = 1'b1; end
            OP_SUB_H:   begin c.sub_lo = 1'b1; c.sub_hi = 1'b1; end
            OP_ADD_B:   c.byte_mode = 1'b1;
            OP_SUB_B:   begin c.byte_mode = 1'b1; c.sub_byte = 1'b1; end
            default:    c.undef = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/phu_lane.sv
// One lane: widened add/subtract, result is the upper W bits.
module phu_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    localparam int WX = W + 1;

    logic [WX-1:0] wide;

    always_comb begin
        if (sub) wide = {1'b0, a} - {1'b0, b};
        else     wide = {1'b0, a} + {1'b0, b};
    end

    assign y = wide[WX-1:1];
endmodule

// File: rtl/phu_half_path.sv
module phu_half_path
    import phu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  phu_ctrl_t         ctrl,
    output logic [DATA_W-1:0] y
);
    localparam int HW = DATA_W / 2;

    logic [1:0] lane_sub;
    assign lane_sub = {ctrl.sub_hi, ctrl.sub_lo};

    for (genvar i = 0; i < 2; i++) begin : g_half
        logic [HW-1:0] b_sel;
        assign b_sel = ctrl.swap_b ? b[(1-i)*HW +: HW] : b[i*HW +: HW];

        phu_lane #(.W(HW)) u_lane (
            .a   (a[i*HW +: HW]),
            .b   (b_sel),
            .sub (lane_sub[i]),
            .y   (y[i*HW +: HW])
        );
    end
endmodule

// File: rtl/phu_byte_path.sv
module phu_byte_path
    import phu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  phu_ctrl_t         ctrl,
    output logic [DATA_W-1:0] y
);
    localparam int NLANE = DATA_W / BYTE_W;

    for (genvar k = 0; k < NLANE; k++) begin : g_byte
        phu_lane #(.W(BYTE_W)) u_lane (
            .a   (a[k*BYTE_W +: BYTE_W]),
            .b   (b[k*BYTE_W +: BYTE_W]),
            .sub (ctrl.sub_byte),
            .y   (y[k*BYTE_W +: BYTE_W])
        );
    end
endmodule

// File: rtl/phu_unit.sv
module phu_unit
    import phu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_undef
);
    phu_ctrl_t         ctrl;
    logic [DATA_W-1:0] half_y;
    logic [DATA_W-1:0] byte_y;
    logic [DATA_W-1:0] next_y;

    assign ctrl = phu_decode(phu_op_e'(op_sel));

    phu_half_path #(.DATA_W(DATA_W)) u_half (
        .a    (opnd_a),
        .b    (opnd_b),
        .ctrl (ctrl),
        .y    (half_y)
    );

    phu_byte_path #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_byte (
        .a    (opnd_a),
        .b    (opnd_b),
        .ctrl (ctrl),
        .y    (byte_y)
    );

    assign next_y = ctrl.byte_mode ? byte_y : half_y;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_undef  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            out_undef <= in_valid & ctrl.undef;
            if (in_valid && !ctrl.undef) out_result <= next_y;
        end
    end
endmodule

// File: rtl/phu_unit_chk.sv
module phu_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [2:0]        op_sel,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic              out_undef
);
    logic rsv_op;
    assign rsv_op = (op_sel == 3'd5) || (op_sel == 3'd6);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_undef && out_result == '0)); // R11

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R10

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_undef && $stable(out_result))); // R10

    AST_UNDEF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rsv_op) |=> (out_undef && $stable(out_result))); // R9

    AST_DEFINED_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !rsv_op) |=> !out_undef); // R10

    AST_BYTE_BORROW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'd7 && opnd_a[7:0] < opnd_b[7:0]) |=> out_result[7]); // R7

    AST_HALF_BORROW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'd3 && opnd_a[31:16] < opnd_b[31:16]) |=> out_result[31]); // R7
endmodule

bind phu_unit phu_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op_sel     (op_sel),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_undef  (out_undef)
);

// File: tb/phu_unit_tb.sv
module phu_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_undef;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // expected state of the outputs
    logic        exp_v = 1'b0;
    logic        exp_u = 1'b0;
    logic [31:0] exp_r = '0;

    always #10 clk = ~clk;

    phu_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid),
        .out_result(out_result), .out_undef(out_undef)
    );

    function automatic logic [31:0] ref_calc(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        int al, ah, bl, bh, lo, hi, s;
        logic [31:0] r;
        al = int'(a[15:0]); ah = int'(a[31:16]);
        bl = int'(b[15:0]); bh = int'(b[31:16]);
        lo = 0; hi = 0; r = '0;
        case (op)
            3'd0: begin lo = al + bl; hi = ah + bh; end
            3'd1: begin lo = al - bh; hi = ah + bl; end
            3'd2: begin lo = al + bh; hi = ah - bl; end
            3'd3: begin lo = al - bl; hi = ah - bh; end
            default: ;
        endcase
        r = {hi[16:1], lo[16:1]};
        if (op == 3'd4 || op == 3'd7) begin
            for (int k = 0; k < 4; k++) begin
                if (op == 3'd4) s = int'(a[8*k +: 8]) + int'(b[8*k +: 8]);
                else            s = int'(a[8*k +: 8]) - int'(b[8*k +: 8]);
                r[8*k +: 8] = s[8:1];
            end
        end
        return r;
    endfunction

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd7: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic compare(input string tag);
        n_vec++;
        if (out_valid !== exp_v || out_undef !== exp_u || out_result !== exp_r) begin
            n_bad++;
            $display("FAIL %s: got v=%b u=%b r=%h, expected v=%b u=%b r=%h",
                     tag, out_valid, out_undef, out_result, exp_v, exp_u, exp_r);
        end
    endtask

    task automatic step(input logic v, input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input string tag);
        @(negedge clk);
        in_valid = v; op_sel = op; opnd_a = a; opnd_b = b;
        @(posedge clk);
        exp_v = v;
        exp_u = v && (op == 3'd5 || op == 3'd6);
        if (v && !(op == 3'd5 || op == 3'd6)) exp_r = ref_calc(op, a, b);
        #5;
        compare(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        exp_v = 1'b0; exp_u = 1'b0; exp_r = '0;
        #5;
        compare("R11 reset");
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // directed corners for every select code
        for (int op = 0; op < 8; op++) begin
            string t;
            t = op_tag(3'(op));
            step(1'b1, 3'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF, {t, " all ones"});
            step(1'b1, 3'(op), 32'h0000_0000, 32'h0000_0000, {t, " zeros"});
            step(1'b1, 3'(op), 32'h1020_3040, 32'h8090_A0B0, {t, " R7 A<B every lane"});
            step(1'b1, 3'(op), 32'h0000_0000, 32'hFFFF_FFFF, {t, " R7 zero minus ones"});
            step(1'b1, 3'(op), 32'h00FF_00FF, 32'h0001_0001, {t, " R8 boundary carry"});
            step(1'b1, 3'(op), 32'hFF00_FF00, 32'h0100_0100, {t, " R8 upper carry"});
            step(1'b1, 3'(op), 32'h0001_0000, 32'h0000_0001, {t, " R8 borrow edge"});
        end

        // undefined selects directly after a defined result, then idle
        step(1'b1, 3'd0, 32'h1234_5678, 32'h9ABC_DEF0, "R1 setup");
        step(1'b1, 3'd5, 32'hFFFF_FFFF, 32'h0000_0001, "R9 select 5 hold");
        step(1'b1, 3'd6, 32'h0F0F_0F0F, 32'hF0F0_F0F0, "R9 select 6 hold");
        step(1'b0, 3'd4, 32'hAAAA_AAAA, 32'h5555_5555, "R10 idle hold");
        step(1'b0, 3'd5, 32'hAAAA_AAAA, 32'h5555_5555, "R10 idle undef");
        step(1'b1, 3'd7, 32'h0102_0304, 32'h0403_0201, "R6 after idle");

        // mixed stimulus
        for (int i = 0; i < 600; i++) begin
            logic [2:0] op;
            logic v;
            op = 3'($urandom_range(0, 7));
            v  = ($urandom_range(0, 3) != 0);
            step(v, op, $urandom, $urandom, {op_tag(op), " R10 mixed"});
        end

        do_reset();
        step(1'b1, 3'd2, 32'h8000_0001, 32'h0001_8000, "R3 after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule